// File: doc/BRIEF.md
# Dual-Comparator Memory Breakpoint Unit

This unit watches one of four memory address buses (program, X data, Y data, DMA) and raises a one-cycle breakpoint request toward the debug controller. Each cycle it latches the address on the chosen bus together with the read and write strobes. Two comparators then test the latched address against their own limit registers. Each comparator has its own relation (not equal, equal, less than, greater than) and its own access-type qualifier.

The two comparator results are combined into one qualifying event. The combination is AND, OR, or one of two ordered sequences in which one comparator must have matched in an earlier cycle before the other one counts. A down-counter then lets a chosen number of events pass before the request fires. Software loads the control word, both limits and the counter through plain write-enable ports.

Top module: `mem_break_unit`

## Requirements
- R1: Control bits [1:0] select the latched bus: 00 DMA, 01 program, 10 X, 11 Y. Addresses on the other buses have no effect.
- R2: A comparator's qualifier (bits [3:2] for comparator 0, bits [7:6] for comparator 1) selects the access types it accepts: 00 none, 01 write strobe only, 10 read strobe only, 11 either strobe.
- R3: A comparator's relation (bits [5:4] for comparator 0, bits [9:8] for comparator 1) compares the latched address A with its limit L: 00 A!=L, 01 A==L, 10 A<L, 11 A>L, all unsigned.
- R4: With combine bits [11:10] = 00, an event needs both comparators to match in the same cycle.
- R5: With combine bits = 01, a match of either comparator is an event.
- R6: With combine bits = 10, a comparator 0 match arms a sticky flag. A later comparator 1 match while the flag is armed is an event. Firing the breakpoint clears the flag.
- R7: With combine bits = 11, the order is reversed: comparator 1 arms the flag and a later comparator 0 match is the event.
- R8: The counter is loaded with N-1. Each event while it is non-zero decrements it, and the Nth event raises the breakpoint.
- R9: The counter does not wrap. After a breakpoint it stays at zero, so every further event raises the breakpoint until the counter is reloaded.
- R10: A write of the control word clears the armed flag of the ordered modes.
- R11: A comparator with qualifier 00 never matches. In AND mode this blocks every breakpoint.
- R12: The breakpoint request is high for exactly one cycle. It is high two clock edges after the access is presented: one edge latches the access and the next registers the request.
- R13: After reset the control word, both limits and the counter are zero and the request is low. With that state, no access raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_addr | input | 24 | Program address bus |
| xdat_addr | input | 24 | X data address bus |
| ydat_addr | input | 24 | Y data address bus |
| dma_addr | input | 24 | DMA address bus |
| acc_rd | input | 1 | Read strobe of the current access |
| acc_wr | input | 1 | Write strobe of the current access |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 24 | Control word; bits [23:12] are ignored |
| lim0_we | input | 1 | Limit 0 write enable |
| lim0_wdata | input | 24 | Limit 0 value |
| lim1_we | input | 1 | Limit 1 write enable |
| lim1_wdata | input | 24 | Limit 1 value |
| cnt_we | input | 1 | Occurrence counter load enable |
| cnt_wdata | input | 24 | Occurrence counter load value (N-1) |
| brk_req | output | 1 | One-cycle breakpoint request |

## Verification
The armed flag of the ordered modes is the hardest state to reach and to see. It is internal, and it only shows up as whether a later second-comparator match fires. The stimulus therefore builds explicit histories: second match alone, first then second, a repeat of the second after a fire, and first match followed by a control rewrite and then the second. Counter exhaustion is also tested past zero, by repeating events after the first breakpoint and then reloading.

// File: rtl/mbu_pkg.sv
// Shared encodings for the memory breakpoint unit.
// Assumes the control word layout given in the brief (12 live bits).
package mbu_pkg;
    typedef enum logic [1:0] {BUS_DMA, BUS_PROG, BUS_X, BUS_Y} bus_sel_e;
    typedef enum logic [1:0] {Q_OFF, Q_WR, Q_RD, Q_ANY} qual_e;
    typedef enum logic [1:0] {REL_NE, REL_EQ, REL_LT, REL_GT} rel_e;
    typedef enum logic [1:0] {CMB_AND, CMB_OR, CMB_1_AFTER_0, CMB_0_AFTER_1} comb_e;

    typedef struct packed {
        comb_e    comb;
        rel_e     rel1;
        qual_e    qual1;
        rel_e     rel0;
        qual_e    qual0;
        bus_sel_e bus;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/mbu_addr_latch.sv
// Captures the address of the selected bus and the access strobes every cycle.
// Assumes bus selection is stable for the cycle it is applied to.
module mbu_addr_latch
    import mbu_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_sel_e          bus_sel,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [ADDR_W-1:0] xdat_addr,
    input  logic [ADDR_W-1:0] ydat_addr,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_rd,
    output logic              lat_wr
);
    logic [ADDR_W-1:0] mux_addr;

    // Pick the bus named by the control word.
    always_comb begin
        unique case (bus_sel)
            BUS_DMA:  mux_addr = dma_addr;
            BUS_PROG: mux_addr = prog_addr;
            BUS_X:    mux_addr = xdat_addr;
            default:  mux_addr = ydat_addr;
        endcase
    end

    // Latch address and strobes once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_rd   <= 1'b0;
            lat_wr   <= 1'b0;
        end else begin
            lat_addr <= mux_addr;
            lat_rd   <= acc_rd;
            lat_wr   <= acc_wr;
        end
    end
endmodule

// File: rtl/mbu_comparator.sv
// One address comparator: access qualifier plus unsigned relation to a limit.
// Purely combinational; operates on latched address and strobes.
module mbu_comparator
    import mbu_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] limit,
    input  qual_e             qual,
    input  rel_e              rel,
    output logic              match
);
    logic acc_ok;
    logic rel_ok;

    // Access type qualification.
    always_comb begin
        unique case (qual)
            Q_OFF:   acc_ok = 1'b0;
            Q_WR:    acc_ok = wr;
            Q_RD:    acc_ok = rd;
            default: acc_ok = rd | wr;
        endcase
    end

    // Relation between address and limit.
    always_comb begin
        unique case (rel)
            REL_NE:  rel_ok = (addr != limit);
            REL_EQ:  rel_ok = (addr == limit);
            REL_LT:  rel_ok = (addr <  limit);
            default: rel_ok = (addr >  limit);
        endcase
    end

    assign match = acc_ok & rel_ok;
endmodule

// File: rtl/mbu_event_seq.sv
// Combines two comparator matches into a qualifying event.
// Ordered modes use a sticky armed flag; clear and fire both disarm it.
module mbu_event_seq
    import mbu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  comb_e comb,
    input  logic  m0,
    input  logic  m1,
    input  logic  clr,
    input  logic  fire,
    output logic  event_o
);
    logic armed_q;
    logic first_m;
    logic second_m;

    // Route matches to first/second roles per ordered mode.
    always_comb begin
        first_m  = 1'b0;
        second_m = 1'b0;
        if (comb == CMB_1_AFTER_0) begin
            first_m  = m0;
            second_m = m1;
        end else if (comb == CMB_0_AFTER_1) begin
            first_m  = m1;
            second_m = m0;
        end
    end

    // Produce the event for the selected combination.
    always_comb begin
        unique case (comb)
            CMB_AND: event_o = m0 & m1;
            CMB_OR:  event_o = m0 | m1;
            default: event_o = armed_q & second_m;
        endcase
    end

    // Sticky arm flag; clearing wins over setting.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (clr || fire) armed_q <= 1'b0;
        else if (first_m)     armed_q <= 1'b1;
    end

    a_r10_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> !armed_q);
    a_r6_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire) |-> !armed_q);
endmodule

// File: rtl/mbu_countdown.sv
// Occurrence counter: loaded with N-1, fires on an event at zero, holds at zero.
// A load in the same cycle as an event takes priority and suppresses the event.
module mbu_countdown #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             event_i,
    output logic             fire,
    output logic             brk_q
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign fire    = event_i & at_zero & ~load;

    // Load, or count down on events without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load)                     cnt_q <= load_val;
        else if (event_i && !at_zero)      cnt_q <= cnt_q - 1'b1;
    end

    // Register the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_q <= 1'b0;
        else        brk_q <= fire;
    end

    a_r9_fire_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> ($past(cnt_q) == '0));
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/mem_break_unit.sv
// Top of the memory breakpoint unit: configuration registers, bus latch,
// two comparators, event combiner and occurrence counter.
// Register writes take effect on the cycle after the write edge.
module mem_break_unit
    import mbu_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 24,
    parameter int CTRL_IN_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    prog_addr,
    input  logic [ADDR_W-1:0]    xdat_addr,
    input  logic [ADDR_W-1:0]    ydat_addr,
    input  logic [ADDR_W-1:0]    dma_addr,
    input  logic                 acc_rd,
    input  logic                 acc_wr,
    input  logic                 ctrl_we,
    input  logic [CTRL_IN_W-1:0] ctrl_wdata,
    input  logic                 lim0_we,
    input  logic [ADDR_W-1:0]    lim0_wdata,
    input  logic                 lim1_we,
    input  logic [ADDR_W-1:0]    lim1_wdata,
    input  logic                 cnt_we,
    input  logic [CNT_W-1:0]     cnt_wdata,
    output logic                 brk_req
);
    localparam int NCMP = 2;

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] lim_q [NCMP];
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_rd;
    logic              lat_wr;
    logic [NCMP-1:0]   match;
    qual_e             qual_a [NCMP];
    rel_e              rel_a  [NCMP];
    logic              ev;
    logic              fire;
    logic              unused_ctrl_hi;

    assign unused_ctrl_hi = ^ctrl_wdata[CTRL_IN_W-1:CTRL_W];

    // Control word register; reserved bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata[CTRL_W-1:0]);
    end

    // Limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q[0] <= '0;
            lim_q[1] <= '0;
        end else begin
            if (lim0_we) lim_q[0] <= lim0_wdata;
            if (lim1_we) lim_q[1] <= lim1_wdata;
        end
    end

    assign qual_a[0] = ctrl_q.qual0;
    assign qual_a[1] = ctrl_q.qual1;
    assign rel_a[0]  = ctrl_q.rel0;
    assign rel_a[1]  = ctrl_q.rel1;

    mbu_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .bus_sel(ctrl_q.bus),
        .prog_addr(prog_addr), .xdat_addr(xdat_addr),
        .ydat_addr(ydat_addr), .dma_addr(dma_addr),
        .acc_rd(acc_rd), .acc_wr(acc_wr),
        .lat_addr(lat_addr), .lat_rd(lat_rd), .lat_wr(lat_wr)
    );

    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
        mbu_comparator #(.ADDR_W(ADDR_W)) u_cmp (
            .addr(lat_addr), .rd(lat_rd), .wr(lat_wr),
            .limit(lim_q[gi]), .qual(qual_a[gi]), .rel(rel_a[gi]),
            .match(match[gi])
        );
    end

    mbu_event_seq u_seq (
        .clk(clk), .rst_n(rst_n), .comb(ctrl_q.comb),
        .m0(match[0]), .m1(match[1]), .clr(ctrl_we), .fire(fire),
        .event_o(ev)
    );

    mbu_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_we), .load_val(cnt_wdata),
        .event_i(ev), .fire(fire), .brk_q(brk_req)
    );

    a_r11_off_never_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.qual0 == Q_OFF) |-> !match[0]);
    a_r11_and_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.comb == CMB_AND && (ctrl_q.qual0 == Q_OFF || ctrl_q.qual1 == Q_OFF)) |-> !ev);
    a_r12_request_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(ev));
endmodule

// File: tb/mem_break_unit_tb.sv
// Directed bench for mem_break_unit.
module mem_break_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] prog_addr = '0, xdat_addr = '0, ydat_addr = '0, dma_addr = '0;
    logic        acc_rd = 1'b0, acc_wr = 1'b0;
    logic        ctrl_we = 1'b0, lim0_we = 1'b0, lim1_we = 1'b0, cnt_we = 1'b0;
    logic [23:0] ctrl_wdata = '0, lim0_wdata = '0, lim1_wdata = '0, cnt_wdata = '0;
    logic        brk_req;
    int          n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    mem_break_unit u_dut (
        .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .xdat_addr(xdat_addr),
        .ydat_addr(ydat_addr), .dma_addr(dma_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .lim0_we(lim0_we),
        .lim0_wdata(lim0_wdata), .lim1_we(lim1_we), .lim1_wdata(lim1_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .brk_req(brk_req)
    );

    function automatic logic [23:0] mk_ctrl(input int sel, q0, c0, q1, c1, cmb);
        logic [23:0] v;
        v = '0;
        v[1:0] = sel[1:0]; v[3:2] = q0[1:0]; v[5:4] = c0[1:0];
        v[7:6] = q1[1:0];  v[9:8] = c1[1:0]; v[11:10] = cmb[1:0];
        v[23:12] = 12'hA5C;
        return v;
    endfunction

    function automatic bit rel_ref(input int c, input logic [23:0] a, l);
        case (c)
            0: return a != l;
            1: return a == l;
            2: return a < l;
            default: return a > l;
        endcase
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic wr_cfg(input logic [23:0] c, l0, l1, cn);
        @(negedge clk);
        ctrl_we = 1; ctrl_wdata = c; lim0_we = 1; lim0_wdata = l0;
        lim1_we = 1; lim1_wdata = l1; cnt_we = 1; cnt_wdata = cn;
        @(negedge clk);
        ctrl_we = 0; lim0_we = 0; lim1_we = 0; cnt_we = 0;
    endtask

    // Present one access, return whether brk_req rose two edges later.
    task automatic acc4(input logic [23:0] p, x, y, d, input bit rd, wr, output bit fired);
        @(negedge clk);
        prog_addr = p; xdat_addr = x; ydat_addr = y; dma_addr = d;
        acc_rd = rd; acc_wr = wr;
        @(negedge clk);
        acc_rd = 0; acc_wr = 0;
        @(negedge clk);
        fired = brk_req;
    endtask

    task automatic acc(input logic [23:0] a, input bit rd, wr, output bit fired);
        acc4(a, 24'h0, 24'h0, 24'h0, rd, wr, fired);
    endtask

    task automatic t_reset();
        bit f;
        check(brk_req, 0, "R13 reset level");
        acc4(24'h0, 24'h0, 24'h0, 24'h0, 1, 1, f);
        check(f, 0, "R13 idle after reset");
    endtask

    task automatic t_bus_sel();
        bit f;
        logic [23:0] t = 24'h123456, o = 24'h000777;
        for (int s = 0; s < 4; s++) begin
            wr_cfg(mk_ctrl(s, 3, 1, 0, 0, 1), t, 24'h0, 24'h0);
            acc4(s == 1 ? t : o, s == 2 ? t : o, s == 3 ? t : o, s == 0 ? t : o, 1, 0, f);
            check(f, 1, $sformatf("R1 bus %0d selected", s));
            acc4(s == 1 ? o : t, s == 2 ? o : t, s == 3 ? o : t, s == 0 ? o : t, 1, 0, f);
            check(f, 0, $sformatf("R1 bus %0d others ignored", s));
        end
    endtask

    task automatic t_qual();
        bit f;
        for (int q = 0; q < 4; q++) begin
            wr_cfg(mk_ctrl(1, q, 1, 0, 0, 1), 24'h40, 24'h0, 24'h0);
            acc(24'h40, 0, 1, f); check(f, q == 1 || q == 3, $sformatf("R2 qual %0d write", q));
            acc(24'h40, 1, 0, f); check(f, q == 2 || q == 3, $sformatf("R2 qual %0d read", q));
            acc(24'h40, 1, 1, f); check(f, q != 0, $sformatf("R11 qual %0d both strobes", q));
            acc(24'h40, 0, 0, f); check(f, 0, $sformatf("R2 qual %0d no strobe", q));
        end
    endtask

    task automatic t_rel();
        bit f;
        logic [23:0] lim = 24'h001000;
        for (int c = 0; c < 4; c++) begin
            wr_cfg(mk_ctrl(1, 0, 0, 3, c, 1), 24'h0, lim, 24'h0);
            for (int k = -1; k <= 1; k++) begin
                logic [23:0] a = lim + 24'(k);
                acc(a, 1, 0, f);
                check(f, rel_ref(c, a, lim), $sformatf("R3 cond %0d addr %h", c, a));
            end
        end
    endtask

    task automatic t_and();
        bit f;
        wr_cfg(mk_ctrl(1, 3, 3, 3, 2, 0), 24'h100, 24'h200, 24'h0);
        acc(24'h150, 1, 0, f); check(f, 1, "R4 both match");
        acc(24'h250, 1, 0, f); check(f, 0, "R4 only c0");
        acc(24'h050, 1, 0, f); check(f, 0, "R4 only c1");
        wr_cfg(mk_ctrl(1, 3, 3, 0, 2, 0), 24'h100, 24'h200, 24'h0);
        acc(24'h150, 1, 0, f); check(f, 0, "R11 AND with c1 off");
    endtask

    task automatic t_or();
        bit f;
        wr_cfg(mk_ctrl(1, 3, 1, 3, 1, 1), 24'h10, 24'h20, 24'h0);
        acc(24'h10, 1, 0, f); check(f, 1, "R5 c0 only");
        acc(24'h20, 0, 1, f); check(f, 1, "R5 c1 only");
        acc(24'h30, 1, 0, f); check(f, 0, "R5 neither");
    endtask

    task automatic t_seq10();
        bit f;
        wr_cfg(mk_ctrl(1, 3, 1, 3, 1, 2), 24'hA0, 24'hB0, 24'h0);
        acc(24'hB0, 1, 0, f); check(f, 0, "R6 second without first");
        acc(24'hA0, 1, 0, f); check(f, 0, "R6 first arms only");
        acc(24'h55, 1, 0, f); check(f, 0, "R6 unrelated access");
        acc(24'hB0, 1, 0, f); check(f, 1, "R6 second after first");
        acc(24'hB0, 1, 0, f); check(f, 0, "R6 disarmed after fire");
    endtask

    task automatic t_seq01();
        bit f;
        wr_cfg(mk_ctrl(1, 3, 1, 3, 1, 3), 24'hA0, 24'hB0, 24'h0);
        acc(24'hA0, 1, 0, f); check(f, 0, "R7 c0 without c1");
        acc(24'hB0, 1, 0, f); check(f, 0, "R7 c1 arms");
        acc(24'hA0, 1, 0, f); check(f, 1, "R7 c0 after c1");
    endtask

    task automatic t_clear();
        bit f;
        wr_cfg(mk_ctrl(1, 3, 1, 3, 1, 2), 24'hA0, 24'hB0, 24'h0);
        acc(24'hA0, 1, 0, f); check(f, 0, "R10 arm");
        @(negedge clk); ctrl_we = 1; ctrl_wdata = mk_ctrl(1, 3, 1, 3, 1, 2);
        @(negedge clk); ctrl_we = 0;
        acc(24'hB0, 1, 0, f); check(f, 0, "R10 rewrite disarms");
        acc(24'hA0, 1, 0, f);
        acc(24'hB0, 1, 0, f); check(f, 1, "R10 rearm works");
    endtask

    task automatic t_count();
        bit f;
        wr_cfg(mk_ctrl(1, 3, 1, 0, 0, 1), 24'h77, 24'h0, 24'd2);
        acc(24'h77, 1, 0, f); check(f, 0, "R8 event 1 of 3");
        acc(24'h77, 1, 0, f); check(f, 0, "R8 event 2 of 3");
        acc(24'h77, 1, 0, f); check(f, 1, "R8 event 3 of 3");
        @(negedge clk); check(brk_req, 0, "R12 one-cycle pulse");
        acc(24'h77, 1, 0, f); check(f, 1, "R9 holds at zero");
        @(negedge clk); cnt_we = 1; cnt_wdata = 24'd1;
        @(negedge clk); cnt_we = 0;
        acc(24'h77, 1, 0, f); check(f, 0, "R9 reload 1 first");
        acc(24'h77, 1, 0, f); check(f, 1, "R9 reload 1 second");
    endtask

    task automatic t_latency();
        @(negedge clk);
        wr_cfg(mk_ctrl(1, 3, 1, 0, 0, 1), 24'h99, 24'h0, 24'h0);
        @(negedge clk); prog_addr = 24'h99; acc_rd = 1;
        @(negedge clk); acc_rd = 0; check(brk_req, 0, "R12 not after one edge");
        @(negedge clk); check(brk_req, 1, "R12 high after two edges");
        @(negedge clk); check(brk_req, 0, "R12 low after pulse");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_bus_sel();
        t_qual();
        t_rel();
        t_and();
        t_or();
        t_seq10();
        t_seq01();
        t_clear();
        t_count();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule